// File: doc/BRIEF.md
# Dual-Channel PWM Generator with Register Port

This block produces two independent pulse-width modulated outputs. Each channel is configured through a small 32-bit register port: one control word is shared by both channels, and each channel has its own word that holds the period and the active length. Each channel divides the system clock by a selectable prescaler. A counter then runs over the resulting ticks from zero up to the programmed period limit. The output is in its active state while the count is below the programmed duty value. A polarity bit chooses whether the active state is driven high or low.

A write to a channel's period/duty word goes first into a shadow copy, and the channel's ready flag in the control word is raised. The shadow copy is moved into the working registers at the next period boundary, or on the next clock if the channel is stopped, and the ready flag then drops. While the flag is up, further writes to that channel's word are discarded. This means a running waveform never sees a half-updated period/duty pair.

A channel stops when its enable bit is clear, when its clock gate bit is clear, or when its prescaler code is unsupported. A stopped channel holds its counters at zero and parks its output at the inactive level. Software can therefore drop the gate, change the prescaler and raise the gate again without producing a stray pulse.

Top module: `dual_pwm_ctrl`

## Requirements
- R1: The control word is at byte address 0x0, the channel 0 period/duty word is at 0x4 and the channel 1 word is at 0x8. Channel n uses control bits [15n+9:15n]. Within those bits, [3:0] is the prescaler code, bit 4 enables the channel, bit 5 is the polarity and bit 6 is the clock gate. Bits 7 to 9 are plain storage. A read of the control word returns these ten bits per channel, and every other bit reads 0 apart from the ready flags. Any other address reads 0.
- R2: A channel runs only while its enable and gate bits are both 1 and its prescaler code is supported. Otherwise its counters are held at zero and its output sits at the inactive level. That level is 0 when polarity is 1 and 1 when polarity is 0, and the output reaches it in the cycle after the control write.
- R3: Prescaler code 15 advances the counter on every clock. Codes 0 to 7 advance it once every 2^(code+1) clocks. Codes 8 to 14 are unsupported and stop the channel.
- R4: In the period/duty word, bits [31:16] hold the period minus one (P) and bits [15:0] hold the duty D. One period lasts P+1 ticks, and the counter starts at 0 in the cycle after the channel is started.
- R5: The output is active while the count is below D. D = 0 never produces an active state, and D > P produces an active state for the whole period.
- R6: With polarity 1 the active state drives the pin high. With polarity 0 it drives the pin low.
- R7: A write to a period/duty word stores the value in a shadow copy and sets that channel's ready flag (control bit 28+n). The shadow copy moves into the working registers, and the flag clears, at the tick that ends a period. If the channel is stopped, this happens at the next clock edge.
- R8: A write to a period/duty word while its ready flag is 1 is dropped. A read of a period/duty word returns the shadow copy.
- R9: The two channels are independent. A stopped channel's output stays at its inactive level while the other channel runs.
- R10: After reset every register reads 0, both ready flags are 0, and both outputs are 1 (the idle level for polarity 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pwm_out | output | 2 | PWM pins, bit n belongs to channel n |

## Verification
The bench counts how many cycles each output is high over a window of exactly two periods. This catches an off-by-one in the period length or the prescaler, which would shift the count by one tick times the divider. It also drives the duty corners zero, above the period, and a period field of zero, where a design with the wrong compare would produce a pulse or a gap. It writes a second value while an update is still pending and reads it back, so a design that does not drop that write shows the wrong shadow value. It also reads the ready flag in the exact cycles around an update of a stopped channel. Finally it drops the gate, changes the prescaler and raises the gate again, and checks the pin after each step for a stray active level.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned CH_STRIDE  = 15;
  localparam int unsigned FIELD_W    = 10;
  localparam int unsigned PSC_W      = 4;
  localparam int unsigned HALF_W     = 16;
  localparam int unsigned READY_BASE = 28;

  typedef struct packed {
    logic             aux2;
    logic             aux1;
    logic             aux0;
    logic             gate;
    logic             pol;
    logic             en;
    logic [PSC_W-1:0] psc;
  } chan_cfg_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned MAX_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic              tick_o
);
  localparam int unsigned CNT_W = MAX_SHIFT;
  localparam logic [CODE_W-1:0] BYPASS = {CODE_W{1'b1}};

  logic [CNT_W-1:0] pre_q, pre_n, lim;

  always_comb begin
    valid_o = 1'b0;
    lim     = '0;
    if (code_i == BYPASS) begin
      valid_o = 1'b1;
    end else if (int'(code_i) < int'(MAX_SHIFT)) begin
      valid_o = 1'b1;
      lim     = CNT_W'((64'd1 << (int'(code_i) + 1)) - 64'd1);
    end
  end

  assign tick_o = run_i && (pre_q == lim);

  always_comb begin
    if (!run_i)      pre_n = '0;
    else if (tick_o) pre_n = '0;
    else             pre_n = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_n;
  end

  // R3: divider count never passes its limit
  a_r3_pre_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (pre_q <= lim));
  // R2: a stopped channel clears its divider
  a_r2_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pre_q == '0));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned HALF_W    = 16,
  parameter int unsigned CODE_W    = 4,
  parameter int unsigned MAX_SHIFT = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CODE_W-1:0]   psc_i,
  input  logic                en_i,
  input  logic                pol_i,
  input  logic                gate_i,
  input  logic                wr_i,
  input  logic [2*HALF_W-1:0] wdata_i,
  output logic                pend_o,
  output logic [2*HALF_W-1:0] shadow_o,
  output logic                pwm_o
);
  logic                valid, tick, run, wrap, load, accept;
  logic [2*HALF_W-1:0] shadow_q, shadow_n;
  logic                pend_q, pend_n;
  logic [HALF_W-1:0]   prd_q, prd_n, dty_q, dty_n, cnt_q, cnt_n;
  logic                active;

  pwm_prescaler #(.CODE_W(CODE_W), .MAX_SHIFT(MAX_SHIFT)) psc_i0 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .code_i(psc_i),
    .valid_o(valid), .tick_o(tick)
  );

  assign run    = en_i && gate_i && valid;
  assign wrap   = tick && (cnt_q == prd_q);
  assign load   = pend_q && (wrap || !run);
  assign accept = wr_i && !pend_q;

  always_comb begin
    shadow_n = shadow_q;
    pend_n   = pend_q;
    prd_n    = prd_q;
    dty_n    = dty_q;
    if (load) begin
      prd_n  = shadow_q[2*HALF_W-1:HALF_W];
      dty_n  = shadow_q[HALF_W-1:0];
      pend_n = 1'b0;
    end else if (accept) begin
      shadow_n = wdata_i;
      pend_n   = 1'b1;
    end
    if (!run)      cnt_n = '0;
    else if (wrap) cnt_n = '0;
    else if (tick) cnt_n = cnt_q + 1'b1;
    else           cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pend_q   <= 1'b0;
      prd_q    <= '0;
      dty_q    <= '0;
      cnt_q    <= '0;
    end else begin
      shadow_q <= shadow_n;
      pend_q   <= pend_n;
      prd_q    <= prd_n;
      dty_q    <= dty_n;
      cnt_q    <= cnt_n;
    end
  end

  assign active   = run && (cnt_q < dty_q);
  assign pwm_o    = pol_i ? active : !active;
  assign pend_o   = pend_q;
  assign shadow_o = shadow_q;

  // R4: count stays within the working period
  a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= prd_q);
  // R2: stopping a channel returns its counter to zero
  a_r2_cnt_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
  // R7: an update only lands at the start of a period
  a_r7_load_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pend_q) |-> (cnt_q == '0));
  // R8: the shadow copy is frozen while an update waits
  a_r8_shadow_keep: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> $stable(shadow_q));
endmodule

// File: rtl/dual_pwm_ctrl.sv
module dual_pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned MAX_SHIFT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int unsigned WORD_SEL_W = ADDR_W - 2;

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [WORD_SEL_W-1:0] word_sel;
  logic                  aligned;
  assign word_sel = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);

  chan_cfg_t           ctrl_q [NUM_CH];
  chan_cfg_t           ctrl_n [NUM_CH];
  logic [NUM_CH-1:0]   pend;
  logic [REG_W-1:0]    shadow [NUM_CH];
  logic                ctrl_we;
  assign ctrl_we = bus_we && aligned && (word_sel == '0);

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      logic ch_we;
      assign ch_we = bus_we && aligned && (int'(word_sel) == g + 1);

      always_comb begin
        ctrl_n[g] = ctrl_q[g];
        if (ctrl_we) ctrl_n[g] = chan_cfg_t'(bus_wdata[g*CH_STRIDE +: FIELD_W]);
      end

      always_ff @(posedge clk or negedge rst_int_n) begin
        if (!rst_int_n) ctrl_q[g] <= '0;
        else            ctrl_q[g] <= ctrl_n[g];
      end

      pwm_chan #(.HALF_W(HALF_W), .CODE_W(PSC_W), .MAX_SHIFT(MAX_SHIFT)) chan_i (
        .clk(clk), .rst_n(rst_int_n),
        .psc_i(ctrl_q[g].psc), .en_i(ctrl_q[g].en),
        .pol_i(ctrl_q[g].pol), .gate_i(ctrl_q[g].gate),
        .wr_i(ch_we), .wdata_i(bus_wdata),
        .pend_o(pend[g]), .shadow_o(shadow[g]), .pwm_o(pwm_out[g])
      );

      // R1: ready flags are read-only, a control write cannot raise one
      a_r1_ready_ro: assert property (@(posedge clk) disable iff (!rst_int_n)
        (ctrl_we && !pend[g]) |=> !pend[g]);
    end
  endgenerate

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      if (word_sel == '0) begin
        for (int n = 0; n < NUM_CH; n++) begin
          bus_rdata[n*CH_STRIDE +: FIELD_W] = ctrl_q[n];
          bus_rdata[READY_BASE + n]         = pend[n];
        end
      end else begin
        for (int n = 0; n < NUM_CH; n++) begin
          if (int'(word_sel) == n + 1) bus_rdata = shadow[n];
        end
      end
    end
  end
endmodule

// File: tb/dual_pwm_ctrl_tb.sv
`timescale 1ns/1ps
module dual_pwm_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dual_pwm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // vector: ch, code, pol, period field, duty
  localparam int NV = 11;
  localparam logic [37:0] VEC [NV] = '{
    {1'b0, 4'hF, 1'b1, 16'd9, 16'd3},
    {1'b0, 4'hF, 1'b0, 16'd9, 16'd3},
    {1'b0, 4'h0, 1'b1, 16'd4, 16'd2},
    {1'b0, 4'h2, 1'b1, 16'd3, 16'd1},
    {1'b0, 4'hF, 1'b1, 16'd5, 16'd0},
    {1'b0, 4'hF, 1'b1, 16'd5, 16'd9},
    {1'b1, 4'hF, 1'b1, 16'd7, 16'd5},
    {1'b1, 4'h1, 1'b0, 16'd2, 16'd1},
    {1'b0, 4'h9, 1'b1, 16'd3, 16'd2},
    {1'b0, 4'h7, 1'b1, 16'd1, 16'd1},
    {1'b1, 4'hF, 1'b1, 16'd0, 16'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  function automatic logic [31:0] ctrl_word(input int ch, input logic [3:0] code,
                                            input logic en, input logic pol, input logic gate);
    logic [31:0] f;
    f = {22'd0, 3'b000, gate, pol, en, code};
    return f << (15 * ch);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bus_we = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R10 reset state
    check("R10 outputs", {30'd0, pwm_out}, 32'd3);
    bus_read(4'h0, rd); check("R10 ctrl", rd, 32'd0);
    bus_read(4'h4, rd); check("R10 ch0 word", rd, 32'd0);
    bus_read(4'h8, rd); check("R10 ch1 word", rd, 32'd0);

    // table of vectors: R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      int ch, pol, prd, dty, dv, win, act, hi, cnt;
      logic [3:0] code;
      ch = int'(VEC[v][37]); code = VEC[v][36:33]; pol = int'(VEC[v][32]);
      prd = int'(VEC[v][31:16]); dty = int'(VEC[v][15:0]);
      if (code == 4'hF)   dv = 1;
      else if (code < 8)  dv = 1 << (code + 1);
      else                dv = 0;
      if (dv == 0) begin win = 20; act = 0; end
      else begin
        win = 2 * (prd + 1) * dv;
        act = 2 * ((dty < prd + 1) ? dty : prd + 1) * dv;
      end
      hi = (pol != 0) ? act : win - act;
      bus_write(4'h0, 32'd0);
      bus_write(4'(4 + 4 * ch), VEC[v][31:0]);
      repeat (2) @(negedge clk);
      bus_write(4'h0, ctrl_word(ch, code, 1'b1, pol[0], 1'b1));
      cnt = 0;
      for (int i = 0; i < win; i++) begin
        if (pwm_out[ch]) cnt++;
        if (pwm_out[1 - ch] !== 1'b1) begin
          checks++; fails++;
          $display("FAIL R9 vec %0d: idle channel actual %b expected 1", v, pwm_out[1 - ch]);
        end
        @(negedge clk);
      end
      check($sformatf("R3/R4/R5/R6 vec %0d high cycles", v), cnt, hi);
    end

    // R1 field layout and readback
    bus_write(4'h0, 32'h0FFF_FFFF);
    bus_read(4'h0, rd); check("R1 ctrl readback", rd, 32'h01FF_83FF);
    bus_read(4'hC, rd); check("R1 unmapped read", rd, 32'd0);
    bus_write(4'h0, 32'd0);

    // R2 gate drop, prescaler change, gate restore
    bus_write(4'h4, {16'd3, 16'd9});
    repeat (2) @(negedge clk);
    bus_write(4'h0, ctrl_word(0, 4'hF, 1, 1, 1));
    check("R2 running active", {31'd0, pwm_out[0]}, 32'd1);
    bus_write(4'h0, ctrl_word(0, 4'hF, 1, 1, 0));
    check("R2 gate low inactive", {31'd0, pwm_out[0]}, 32'd0);
    bus_write(4'h0, ctrl_word(0, 4'h0, 1, 1, 0));
    check("R2 prescaler change no glitch", {31'd0, pwm_out[0]}, 32'd0);
    bus_write(4'h0, ctrl_word(0, 4'h0, 1, 1, 1));
    check("R2 gate restored", {31'd0, pwm_out[0]}, 32'd1);
    bus_write(4'h0, ctrl_word(0, 4'h0, 0, 0, 1));
    check("R2 disabled pol0 idle high", {31'd0, pwm_out[0]}, 32'd1);

    // R7 R8 pending update on a running channel
    bus_write(4'h0, 32'd0);
    bus_write(4'h4, {16'd9, 16'd3});
    repeat (2) @(negedge clk);
    bus_write(4'h0, ctrl_word(0, 4'hF, 1, 1, 1));
    @(negedge clk);
    bus_write(4'h4, {16'd4, 16'd4});
    bus_read(4'h0, rd); check("R7 ready set", {31'd0, rd[28]}, 32'd1);
    bus_write(4'h4, {16'd1, 16'd1});
    bus_read(4'h4, rd); check("R8 write dropped", rd, {16'd4, 16'd4});
    repeat (12) @(negedge clk);
    bus_read(4'h0, rd); check("R7 ready clear after wrap", {31'd0, rd[28]}, 32'd0);

    // R7 stopped channel loads on next clock
    bus_write(4'h8, {16'd6, 16'd2});
    bus_read(4'h0, rd); check("R7 ch1 ready set", {31'd0, rd[29]}, 32'd1);
    @(negedge clk);
    bus_read(4'h0, rd); check("R7 ch1 ready clear when stopped", {31'd0, rd[29]}, 32'd0);
    bus_read(4'h8, rd); check("R8 ch1 shadow readback", rd, {16'd6, 16'd2});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule